// File: doc/BRIEF.md
# SD Card Bus Clock Divider

This block derives the card-side bus clock from the controller's input clock. It divides by a power of two from 2 to 512, or passes the input clock straight through. Software programs it through a single control word. The word holds an 8-bit divider code and a run bit. The block guards the word so that only a safe sequence can change the divider: stop the clock, load the new code, then start it again. Writes that break this rule are dropped.

Every accepted change is applied at the end of a period of the divided clock. Because the counter restarts there, the card clock never shows a shortened high or low phase. A stop is the same as a request for zero frequency: the output stays low until the run bit is set again. An idle flag is high while no accepted change is still waiting to be applied. The write guard samples this flag, and a write made while it is low is dropped.

Top module: `sdclk_divider`

## Requirements
- R1: After reset, the card clock is low, `card_clk_on` is 0, the held word `ctrl_rd` is 0x080 (run bit 0, code 0x80) and `div_idle` is 1.
- R2: The control word places the run bit at bit 8 and the divider code at bits 7:0. An accepted write loads it into `ctrl_rd` on the clock edge that samples `wr_en`.
- R3: Code 0x00 divides by 2, and a code with only bit b set divides by 2^(b+2), so 0x80 divides by 512. While running, the card clock has a period of 2^s input cycles and is high for 2^(s-1) of them, where the divisor is 2^s.
- R4: Code 0xFF selects bypass. While running, the card clock then gives one rising edge per input clock cycle.
- R5: A write with the run bit set whose code differs from the held code is ignored.
- R6: A write whose code is not 0x00, not 0xFF and does not have exactly one bit set is ignored.
- R7: A write of code 0xFF is ignored while `bypass_ok` is 0 or `hs400_mode` is 1.
- R8: Any write made while `div_idle` is 0 is ignored.
- R9: While the applied run bit is 0, `card_clk_on` is 0 and the card clock has no edges.
- R10: After an accepted write that changes the held word, `div_idle` is 0 by the next cycle. It returns to 1 once the change is applied. Changes are applied only at a period boundary, with the clock already stopped for a code change, so every change starts on a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, source of the card clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 9 | Control word: bit 8 run, bits 7:0 divider code |
| bypass_ok | input | 1 | Allows the divide-by-1 code |
| hs400_mode | input | 1 | Dual-edge timing mode active; forbids bypass |
| card_clk | output | 1 | Gated, divided card clock |
| card_clk_on | output | 1 | Applied run state of the card clock |
| div_idle | output | 1 | No accepted change is waiting to be applied |
| ctrl_rd | output | 9 | Held control word |

## Verification
The assertions expect `hs400_mode` and `bypass_ok` to change only while no write is presented. They also expect the write strobe to last one cycle per intended write, so each dropped write is seen as a single event. The stimulus drives every input at the falling edge and pulses `wr_en` for exactly one rising edge. It always waits for `div_idle` before a write, except in the one sequence that deliberately writes into a pending change. The clock is sampled at falling edges in divided modes and counted at its own rising edges in bypass.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int CODE_W    = 8;
    localparam int MAX_SHIFT = CODE_W + 1;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
    localparam int CNT_W     = MAX_SHIFT;

    typedef logic [CODE_W-1:0]  div_code_t;
    typedef logic [SHIFT_W-1:0] shift_t;
    typedef logic [CNT_W-1:0]   phase_cnt_t;

    typedef struct packed {
        logic      run;
        div_code_t code;
    } ctrl_word_t;

    localparam div_code_t CODE_BYPASS = '1;
    localparam div_code_t CODE_HALF   = '0;
    localparam div_code_t CODE_RESET  = div_code_t'(1) << (CODE_W - 1);

    function automatic logic code_valid(input div_code_t c);
        return (c == CODE_BYPASS) || (c == CODE_HALF) || $onehot(c);
    endfunction

    // log2 of the divisor: 0 bypass, 1 for /2, bit b -> b+2
    function automatic shift_t code_to_shift(input div_code_t c);
        shift_t s;
        s = shift_t'(MAX_SHIFT);
        if (c == CODE_BYPASS) begin
            s = '0;
        end else if (c == CODE_HALF) begin
            s = shift_t'(1);
        end else begin
            for (int i = 0; i < CODE_W; i++) begin
                if (c[i]) s = shift_t'(i + 2);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/sdclk_reg_guard.sv
module sdclk_reg_guard
    import sdclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_word_t wr_word,
    input  logic       bypass_ok,
    input  logic       hs400_mode,
    input  logic       idle,
    output ctrl_word_t held
);

    logic ok_code, ok_bypass, ok_order, accept;

    always_comb begin
        ok_code   = code_valid(wr_word.code);
        ok_bypass = (wr_word.code != CODE_BYPASS) || (bypass_ok && !hs400_mode);
        ok_order  = !wr_word.run || (wr_word.code == held.code);
        accept    = wr_en && idle && ok_code && ok_bypass && ok_order;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held.run  <= 1'b0;
            held.code <= CODE_RESET;
        end else if (accept) begin
            held <= wr_word;
        end
    end

    p_busy_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idle) |=> $stable(held));

    p_live_code_change_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word.run && (wr_word.code != held.code)) |=> $stable(held));

    p_bad_code_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !code_valid(wr_word.code)) |=> $stable(held));

    p_bypass_forbidden_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_word.code == CODE_BYPASS) && (!bypass_ok || hs400_mode))
        |=> $stable(held));

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
    import sdclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tgt_run,
    input  shift_t tgt_shift,
    output logic   act_run,
    output shift_t act_shift,
    output logic   div_q,
    output logic   idle
);

    phase_cnt_t cnt, cnt_n, mask, shifted;
    logic       boundary, run_n;
    shift_t     shift_n;

    always_comb begin
        mask     = ~({CNT_W{1'b1}} << act_shift);
        boundary = ((cnt & mask) == mask);
        run_n    = act_run;
        shift_n  = act_shift;
        if (boundary) begin
            if (act_run && !tgt_run) begin
                run_n = 1'b0;
            end else if (!act_run && (act_shift != tgt_shift)) begin
                shift_n = tgt_shift;
            end else if (act_run != tgt_run) begin
                run_n = tgt_run;
            end
        end
        cnt_n   = boundary ? '0 : cnt + phase_cnt_t'(1);
        shifted = (shift_n == '0) ? '0 : (cnt_n >> (shift_n - shift_t'(1)));
        idle    = (act_run == tgt_run) && (act_shift == tgt_shift);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            act_run   <= 1'b0;
            act_shift <= shift_t'(MAX_SHIFT);
            div_q     <= 1'b0;
        end else begin
            cnt       <= cnt_n;
            act_run   <= run_n;
            act_shift <= shift_n;
            div_q     <= run_n && (shift_n != '0) && shifted[0];
        end
    end

    p_shift_moves_stopped_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_shift) |-> !$past(act_run));

    p_start_on_low_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(act_run) |-> !div_q);

    p_stopped_is_low_r9: assert property (@(posedge clk) disable iff (rst)
        !act_run |-> !div_q);

endmodule

// File: rtl/sdclk_out_gate.sv
module sdclk_out_gate
    import sdclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   act_run,
    input  shift_t act_shift,
    input  logic   div_q,
    output logic   card_clk
);

    logic byp_sel;
    logic gate_lo;

    assign byp_sel = (act_shift == '0);

    // enable captured while the input clock is low: no partial pulse
    always_ff @(negedge clk) begin
        if (rst) gate_lo <= 1'b0;
        else     gate_lo <= act_run && byp_sel;
    end

    assign card_clk = byp_sel ? (clk & gate_lo) : div_q;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CODE_W:0]     wr_data,
    input  logic                bypass_ok,
    input  logic                hs400_mode,
    output logic                card_clk,
    output logic                card_clk_on,
    output logic                div_idle,
    output logic [CODE_W:0]     ctrl_rd
);

    ctrl_word_t held;
    logic       act_run, div_q, idle;
    shift_t     act_shift, tgt_shift;

    sdclk_reg_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_word   (ctrl_word_t'(wr_data)),
        .bypass_ok (bypass_ok),
        .hs400_mode(hs400_mode),
        .idle      (idle),
        .held      (held)
    );

    assign tgt_shift = code_to_shift(held.code);

    sdclk_div_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tgt_run  (held.run),
        .tgt_shift(tgt_shift),
        .act_run  (act_run),
        .act_shift(act_shift),
        .div_q    (div_q),
        .idle     (idle)
    );

    sdclk_out_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .act_run  (act_run),
        .act_shift(act_shift),
        .div_q    (div_q),
        .card_clk (card_clk)
    );

    assign card_clk_on = act_run;
    assign div_idle    = idle;
    assign ctrl_rd     = held;

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!card_clk_on && (ctrl_rd == {1'b0, CODE_RESET})));

endmodule

// File: tb/sdclk_divider_test.sv
module sdclk_divider_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       bypass_ok = 1'b0;
    logic       hs400_mode = 1'b0;
    logic       card_clk, card_clk_on, div_idle;
    logic [8:0] ctrl_rd;

    int n_total = 0;
    int n_fail  = 0;
    int edges   = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    sdclk_divider uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .bypass_ok(bypass_ok), .hs400_mode(hs400_mode),
        .card_clk(card_clk), .card_clk_on(card_clk_on),
        .div_idle(div_idle), .ctrl_rd(ctrl_rd)
    );

    always @(posedge card_clk) edges++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [8:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (!div_idle && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(div_idle, {tag, " idle timeout"}, int'(div_idle), 1);
    endtask

    task automatic measure(input int s);
        int hi = 0, lo = 0, n = 0;
        logic prev;
        prev = card_clk;
        @(negedge clk);
        while (!(prev == 1'b0 && card_clk == 1'b1) && n < 2000) begin
            prev = card_clk;
            @(negedge clk);
            n++;
        end
        while (card_clk && hi < 2000) begin hi++; @(negedge clk); end
        while (!card_clk && lo < 2000) begin lo++; @(negedge clk); end
        check(hi == (1 << (s - 1)), "R3 high phase", hi, 1 << (s - 1));
        check(hi + lo == (1 << s), "R3 period", hi + lo, 1 << s);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int e0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(card_clk_on == 1'b0, "R1 run", card_clk_on, 0);
        check(ctrl_rd == 9'h080, "R1 word", ctrl_rd, 9'h080);
        check(div_idle == 1'b1, "R1 idle", div_idle, 1);
        e0 = edges;
        repeat (600) @(negedge clk);
        check(edges == e0, "R1 clock quiet", edges - e0, 0);

        // R2 R3 R5 R10: sweep every divided code
        for (int i = 0; i < 9; i++) begin
            logic [7:0] code;
            logic [7:0] other;
            code  = (i == 0) ? 8'h00 : 8'(1 << (i - 1));
            other = (i == 0) ? 8'h01 : 8'h00;
            write_word({1'b0, code});
            wait_idle("R2");
            check(ctrl_rd == {1'b0, code}, "R2 word load", ctrl_rd, {1'b0, code});
            write_word({1'b1, code});
            check(div_idle == 1'b0, "R10 pending after write", div_idle, 0);
            wait_idle("R10");
            check(card_clk_on == 1'b1, "R10 applied run", card_clk_on, 1);
            measure(i + 1);
            write_word({1'b1, other});
            check(ctrl_rd == {1'b1, code}, "R5 live change dropped", ctrl_rd, {1'b1, code});
            write_word({1'b0, code});
            wait_idle("R9");
            check(card_clk_on == 1'b0, "R9 stopped", card_clk_on, 0);
        end

        // R9 stopped clock stays quiet
        e0 = edges;
        repeat (1500) @(negedge clk);
        check(edges == e0, "R9 no edges when stopped", edges - e0, 0);

        // R5 run with a different code while stopped
        write_word({1'b1, 8'h20});
        check(ctrl_rd == 9'h080, "R5 run with new code", ctrl_rd, 9'h080);

        // R6 malformed codes
        write_word({1'b0, 8'h03});
        check(ctrl_rd == 9'h080, "R6 code 0x03", ctrl_rd, 9'h080);
        write_word({1'b0, 8'h81});
        check(ctrl_rd == 9'h080, "R6 code 0x81", ctrl_rd, 9'h080);

        // R7 bypass permission
        bypass_ok = 1'b0;
        write_word({1'b0, 8'hFF});
        check(ctrl_rd == 9'h080, "R7 bypass not allowed", ctrl_rd, 9'h080);
        bypass_ok  = 1'b1;
        hs400_mode = 1'b1;
        write_word({1'b0, 8'hFF});
        check(ctrl_rd == 9'h080, "R7 bypass in hs400", ctrl_rd, 9'h080);
        hs400_mode = 1'b0;
        write_word({1'b0, 8'hFF});
        check(ctrl_rd == 9'h0FF, "R7 bypass accepted", ctrl_rd, 9'h0FF);
        wait_idle("R7");

        // R4 bypass runs at input rate
        write_word({1'b1, 8'hFF});
        wait_idle("R4");
        repeat (3) @(negedge clk);
        e0 = edges;
        repeat (20) @(negedge clk);
        check(edges - e0 == 20, "R4 bypass edges", edges - e0, 20);
        write_word({1'b0, 8'hFF});
        wait_idle("R4");
        repeat (3) @(negedge clk);
        e0 = edges;
        repeat (20) @(negedge clk);
        check(edges == e0, "R9 bypass stopped", edges - e0, 0);

        // R8 write during a pending change
        write_word({1'b0, 8'h80});
        wait_idle("R8");
        write_word({1'b1, 8'h80});
        write_word({1'b0, 8'h40});
        check(ctrl_rd == 9'h180, "R8 busy write dropped", ctrl_rd, 9'h180);
        wait_idle("R8");
        check(card_clk_on == 1'b1, "R8 first change applied", card_clk_on, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule